// File: doc/BRIEF.md
# Per-CPU Process Identifier Controller

This block keeps the 3-bit identifier of the process currently executing on one CPU and presents it, together with a fixed CPU index, to the memory protection and address translation logic. Software loads a new identifier through a small register interface each time it switches context. Protection decisions downstream are taken from this value on every access.

When its automatic mode is enabled, an interrupt strobe makes the block move to the operating-system identifier (value 0) without software help. The interrupted identifier is kept in a shadow register and put back by a return-from-interrupt strobe. Rights therefore change exactly at the exception boundary. One instance is placed per CPU, each with its own index parameter, so two CPUs may run different processes at once.

Top module: `pid_ctrl_top`

## Requirements
- R1: After a synchronous reset the active identifier is 0, the automatic mode is off, no interrupt switch is pending, the shadow holds 0 and the read data is 0.
- R2: A register write to address 0 loads the active identifier from write data bits [2:0]; the output shows it from the clock edge that samples the write.
- R3: The CPU index output always equals the CPU_INDEX parameter.
- R4: With automatic mode on (address 1, bit 0 set) and no switch pending, an interrupt strobe copies the active identifier to the shadow, sets the active identifier to 0 and marks a switch as pending, all at the sampling edge.
- R5: With automatic mode off, an interrupt strobe leaves the active identifier, shadow and pending flag unchanged.
- R6: While a switch is pending, a further interrupt strobe changes neither the active identifier nor the shadow.
- R7: A return strobe while a switch is pending restores the active identifier from the shadow and clears the pending flag; it wins over an interrupt in the same cycle.
- R8: A return strobe with no switch pending has no effect.
- R9: A write to address 0 in the same cycle as an interrupt or return strobe wins: the identifier takes the written value and the pending flag keeps its previous value.
- R10: A read strobe returns, one edge later, address 0: identifier in bits [2:0]; address 1: mode in bit 0; address 2: shadow in bits [2:0] and pending flag in bit 7; address 3: zero. Without a read strobe the read data holds.
- R11: Writes to addresses 2 and 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_in | input | 1 | Interrupt entry strobe |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| pid_out | output | PID_W | Active process identifier |
| cpu_idx | output | 1 | Constant CPU index |

## Verification
The hardest situations to reach are the same-cycle collisions: a software identifier write landing on the very cycle an interrupt or return arrives, and an interrupt arriving while an earlier switch is still pending. The bench drives these strobes together from one task on the same falling edge, sweeping all eight identifiers through a full enter/return round trip, and reads the shadow and pending flag back through address 2 to confirm which event won.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int PID_W_DEF  = 3;
  localparam int DATA_W_DEF = 8;
  localparam int ADDR_W     = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_PID  = 2'd0,
    A_MODE = 2'd1,
    A_STAT = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pid_switch_core.sv
module pid_switch_core #(
  parameter int PID_W  = 3,
  parameter int OS_PID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_en,
  input  logic             irq_in,
  input  logic             irq_ret,
  input  logic             pid_wr,
  input  logic [PID_W-1:0] pid_wdata,
  output logic [PID_W-1:0] pid_q,
  output logic [PID_W-1:0] shadow_q,
  output logic             pending_q
);
  localparam logic [PID_W-1:0] OS_ID = PID_W'(OS_PID);

  always_ff @(posedge clk) begin
    if (rst) begin
      pid_q     <= OS_ID;
      shadow_q  <= OS_ID;
      pending_q <= 1'b0;
    end else if (pid_wr) begin
      pid_q <= pid_wdata;
    end else if (pending_q && irq_ret) begin
      pid_q     <= shadow_q;
      pending_q <= 1'b0;
    end else if (!pending_q && irq_in && auto_en) begin
      shadow_q  <= pid_q;
      pid_q     <= OS_ID;
      pending_q <= 1'b1;
    end
  end

  // R4
  a_r4_enter: assert property (@(posedge clk) disable iff (rst)
    (irq_in && auto_en && !pending_q && !pid_wr) |=>
      (pid_q == OS_ID && pending_q && shadow_q == $past(pid_q)));
  // R5
  a_r5_disabled: assert property (@(posedge clk) disable iff (rst)
    (irq_in && !auto_en && !irq_ret && !pid_wr) |=>
      ($stable(pid_q) && $stable(shadow_q) && $stable(pending_q)));
  // R6
  a_r6_nested: assert property (@(posedge clk) disable iff (rst)
    (irq_in && pending_q && !irq_ret && !pid_wr) |=>
      ($stable(pid_q) && $stable(shadow_q)));
  // R7
  a_r7_restore: assert property (@(posedge clk) disable iff (rst)
    (irq_ret && pending_q && !pid_wr) |=>
      (pid_q == $past(shadow_q) && !pending_q));
  // R9
  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    pid_wr |=> (pid_q == $past(pid_wdata) && pending_q == $past(pending_q)));
endmodule

// File: rtl/pid_regs.sv
module pid_regs #(
  parameter int DATA_W = 8,
  parameter int PID_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [pid_pkg::ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  input  logic [PID_W-1:0]          pid_q,
  input  logic [PID_W-1:0]          shadow_q,
  input  logic                      pending_q,
  output logic [DATA_W-1:0]         reg_rdata,
  output logic                      auto_en,
  output logic                      pid_wr,
  output logic [PID_W-1:0]          pid_wdata
);
  import pid_pkg::*;

  logic [DATA_W-1:0] rd_next;
  logic              unused_wbits;

  assign unused_wbits = ^reg_wdata[DATA_W-1:PID_W];
  assign pid_wr       = reg_wr && (reg_addr == A_PID);
  assign pid_wdata    = reg_wdata[PID_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)
      auto_en <= 1'b0;
    else if (reg_wr && reg_addr == A_MODE)
      auto_en <= reg_wdata[0];
  end

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      A_PID:  rd_next[PID_W-1:0] = pid_q;
      A_MODE: rd_next[0] = auto_en;
      A_STAT: begin
        rd_next[PID_W-1:0]  = shadow_q;
        rd_next[DATA_W-1]   = pending_q;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else if (reg_rd)
      reg_rdata <= rd_next;
  end

  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
  // R11
  a_r11_mode_kept: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr != A_MODE) |=> $stable(auto_en));
endmodule

// File: rtl/pid_ctrl_top.sv
module pid_ctrl_top #(
  parameter int DATA_W    = pid_pkg::DATA_W_DEF,
  parameter int PID_W     = pid_pkg::PID_W_DEF,
  parameter int OS_PID    = 0,
  parameter int CPU_INDEX = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [pid_pkg::ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic                       irq_in,
  input  logic                       irq_ret,
  output logic [PID_W-1:0]           pid_out,
  output logic                       cpu_idx
);
  logic             auto_en;
  logic             pid_wr;
  logic [PID_W-1:0] pid_wdata;
  logic [PID_W-1:0] shadow_q;
  logic             pending_q;

  assign cpu_idx = 1'(CPU_INDEX);

  pid_regs #(.DATA_W(DATA_W), .PID_W(PID_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pid_q(pid_out), .shadow_q(shadow_q), .pending_q(pending_q),
    .reg_rdata(reg_rdata), .auto_en(auto_en),
    .pid_wr(pid_wr), .pid_wdata(pid_wdata)
  );

  pid_switch_core #(.PID_W(PID_W), .OS_PID(OS_PID)) u_core (
    .clk(clk), .rst(rst), .auto_en(auto_en),
    .irq_in(irq_in), .irq_ret(irq_ret),
    .pid_wr(pid_wr), .pid_wdata(pid_wdata),
    .pid_q(pid_out), .shadow_q(shadow_q), .pending_q(pending_q)
  );

  // R8
  a_r8_idle_return: assert property (@(posedge clk) disable iff (rst)
    (irq_ret && !pending_q && !irq_in && !reg_wr) |=> $stable(pid_out));
endmodule

// File: tb/sim_pid_ctrl_top.sv
module sim_pid_ctrl_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       reg_wr, reg_rd, irq_in, irq_ret;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [2:0] pid_out;
  logic       cpu_idx;
  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  pid_ctrl_top #(.CPU_INDEX(1)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_in(irq_in), .irq_ret(irq_ret), .pid_out(pid_out), .cpu_idx(cpu_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle with the given strobes, ends on a falling edge
  task automatic cyc(input logic wr, input logic [1:0] a, input logic [7:0] d,
                     input logic irq, input logic ret);
    reg_wr = wr; reg_addr = a; reg_wdata = d; irq_in = irq; irq_ret = ret;
    @(negedge clk);
    reg_wr = 0; irq_in = 0; irq_ret = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    v = reg_rdata;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    irq_in = 0; irq_ret = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk("R1 pid", int'(pid_out), 0);
    chk("R1 rdata", int'(reg_rdata), 0);
    rd(2'd1, rv); chk("R1 mode", int'(rv), 0);
    rd(2'd2, rv); chk("R1 stat", int'(rv), 0);
    chk("R3 cpu index", int'(cpu_idx), 1);

    // R2 and R5: every id, mode off, irq ignored
    for (int p = 0; p < 8; p++) begin
      cyc(1, 2'd0, 8'(p) | 8'hF8, 0, 0);
      chk("R2 write", int'(pid_out), p);
      rd(2'd0, rv); chk("R10 read pid", int'(rv), p);
      cyc(0, 2'd0, 0, 1, 0);
      chk("R5 disabled irq", int'(pid_out), p);
      rd(2'd2, rv); chk("R5 no pending", int'(rv), 0);
    end

    cyc(1, 2'd1, 8'h01, 0, 0);
    rd(2'd1, rv); chk("R10 read mode", int'(rv), 1);

    // R4/R7 round trip for every id, R6 nested, R8 idle return
    for (int p = 0; p < 8; p++) begin
      cyc(1, 2'd0, 8'(p), 0, 0);
      cyc(0, 2'd0, 0, 0, 1);
      chk("R8 idle return", int'(pid_out), p);
      cyc(0, 2'd0, 0, 1, 0);
      chk("R4 enter", int'(pid_out), 0);
      rd(2'd2, rv); chk("R4 shadow+pending", int'(rv), 128 + p);
      cyc(1, 2'd0, 8'((p + 3) % 8), 0, 0);
      cyc(0, 2'd0, 0, 1, 0);
      chk("R6 nested pid", int'(pid_out), (p + 3) % 8);
      rd(2'd2, rv); chk("R6 nested shadow", int'(rv), 128 + p);
      cyc(0, 2'd0, 0, 1, 1);
      chk("R7 restore", int'(pid_out), p);
      rd(2'd2, rv); chk("R7 cleared", int'(rv), p);
    end

    // R9 collisions
    cyc(1, 2'd0, 8'd5, 0, 0);
    cyc(1, 2'd0, 8'd6, 1, 0);
    chk("R9 write beats irq", int'(pid_out), 6);
    rd(2'd2, rv); chk("R9 no pending", int'(rv[7]), 0);
    cyc(0, 2'd0, 0, 1, 0);
    chk("R4 enter again", int'(pid_out), 0);
    cyc(1, 2'd0, 8'd2, 0, 1);
    chk("R9 write beats return", int'(pid_out), 2);
    rd(2'd2, rv); chk("R9 pending kept", int'(rv), 128 + 6);
    cyc(0, 2'd0, 0, 0, 1);
    chk("R7 late restore", int'(pid_out), 6);

    // R11 writes to status/unused addresses
    cyc(1, 2'd2, 8'hFF, 0, 0);
    cyc(1, 2'd3, 8'hFF, 0, 0);
    chk("R11 pid kept", int'(pid_out), 6);
    rd(2'd2, rv); chk("R11 stat kept", int'(rv), 6);
    rd(2'd1, rv); chk("R11 mode kept", int'(rv), 1);
    rd(2'd3, rv); chk("R10 unused addr", int'(rv), 0);
    reg_addr = 2'd0;
    @(negedge clk);
    chk("R10 hold", int'(reg_rdata), 0);
    chk("R3 cpu index", int'(cpu_idx), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule